// File: doc/BRIEF.md
# Stack Pointer Bounds Guard

This block watches every effective address that the CPU forms through its dedicated stack pointer register. It raises a stack error trap request when the address drops under the fixed base the stack pointer takes at reset (0x0800). It raises the same request when the address climbs past a limit that software programs. The CPU marks each such address with a qualifier flag, and the guard compares it in the same cycle.

The limit register sits on a small bus write port with per-byte enables. Reset leaves the register's contents undefined and the overflow comparison switched off. Only a full word write switches the comparison on. The lower bound check is always active.

The trap request is sticky. It records which bound was crossed and reports the fixed soft-trap priority level (12) while pending. It stays set until the trap logic pulses the clear input.

Top module: `stk_guard`

## Requirements
- R1: After a synchronous active-low reset, `trap_o`, `under_o` and `over_o` are 0, `trap_lvl_o` is 0, and the overflow comparison is disarmed.
- R2: A qualified address (`ea_vld_i`=1) strictly below 0x0800 sets `trap_o` and `under_o` at the next clock edge. An address equal to 0x0800 does not.
- R3: While disarmed, no qualified address at or above 0x0800 raises a trap.
- R4: A write with `lim_be_i`=2'b11 loads `lim_wdata_i` into the limit register, which reads back on `lim_rdata_o` after the edge, and arms the overflow comparison.
- R5: A write with exactly one byte enable set updates only that byte (bit 0 selects bits 7:0, bit 1 selects bits 15:8) and does not arm the comparison.
- R6: While armed, a qualified address that is unsigned-greater than the limit sets `trap_o` and `over_o` at the next edge. An address equal to the limit does not.
- R7: With `ea_vld_i`=0 the address is ignored and no trap is raised.
- R8: A pending trap and its cause flags hold until `trap_clr_i` is sampled high. Causes from later faults are added to the flags already set.
- R9: When a new fault and `trap_clr_i` arrive in the same cycle, the new fault's cause is left set after the edge and older causes are dropped.
- R10: `trap_lvl_o` reads 12 while `trap_o` is set and 0 otherwise.
- R11: An address checked in the same cycle as a limit write is compared against the limit and arm state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ea_i | input | 16 | Effective address formed through the stack pointer |
| ea_vld_i | input | 1 | Stack pointer was the source or destination pointer this cycle |
| lim_wr_i | input | 1 | Limit register write strobe |
| lim_be_i | input | 2 | Byte enables of the limit write |
| lim_wdata_i | input | 16 | Limit write data |
| lim_rdata_o | output | 16 | Current limit register contents |
| trap_clr_i | input | 1 | Clears the pending trap |
| trap_o | output | 1 | Stack error trap request |
| under_o | output | 1 | Trap cause: below reset base |
| over_o | output | 1 | Trap cause: above programmed limit |
| trap_lvl_o | output | 4 | Priority level of the pending trap |

## Verification
The guard holds three pieces of internal state: the arm flag, the limit bytes and the sticky cause flags. A wrong arm flag appears at the ports on the first qualified access above the limit. The trap either fails to rise one edge later, or it rises when it should stay low. A corrupt limit byte shows on `lim_rdata_o` right after the write edge, and it also moves the exact overflow boundary by one or more addresses. A cause flag that is lost or set wrongly shows on `under_o`, `over_o` or `trap_lvl_o` on the edge that follows the fault or the clear.

// File: rtl/stk_guard_pkg.sv
// Package: shared types and constants for the stack bounds guard.
// Assumes: addresses are unsigned and a whole number of bytes wide.
package stk_guard_pkg;

    // Cause of a stack fault, one flag per crossed bound.
    typedef struct packed {
        logic under;
        logic over;
    } stk_fault_t;

    localparam int unsigned LANE_W = 8;

    localparam stk_fault_t FAULT_NONE = '{under: 1'b0, over: 1'b0};

endpackage

// File: rtl/stk_lim_reg.sv
// Module: limit register with byte-lane writes and an arm flag.
// Does: stores the software limit per byte lane; arms on a full-word write.
// Assumes: AW is a multiple of 8; the limit contents are left undefined by reset.
module stk_lim_reg
    import stk_guard_pkg::*;
#(
    parameter int unsigned AW = 16,
    localparam int unsigned NL = AW / LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [NL-1:0] be_i,
    input  logic [AW-1:0] wdata_i,
    output logic [AW-1:0] lim_o,
    output logic          armed_o
);

    logic [AW-1:0] lim_q;
    logic          armed_q;
    logic          word_wr;

    // A write counts as a word write only when every lane is enabled.
    assign word_wr = wr_i && (&be_i);

    // Lane-wise limit update; deliberately not reset.
    always_ff @(posedge clk) begin
        if (wr_i) begin
            for (int l = 0; l < int'(NL); l++) begin
                if (be_i[l]) begin
                    lim_q[l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Arm flag: cleared by reset, set by the first full-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (word_wr) begin
            armed_q <= 1'b1;
        end
    end

    assign lim_o   = lim_q;
    assign armed_o = armed_q;

endmodule

// File: rtl/stk_cmp.sv
// Module: bounds comparator for stack-pointer effective addresses.
// Does: flags underflow against a fixed base and overflow against the limit.
// Assumes: unsigned compare; overflow counted only while armed.
module stk_cmp
    import stk_guard_pkg::*;
#(
    parameter int unsigned   AW   = 16,
    parameter logic [AW-1:0] BASE = 16'h0800
) (
    input  logic          vld_i,
    input  logic [AW-1:0] ea_i,
    input  logic [AW-1:0] lim_i,
    input  logic          armed_i,
    output stk_fault_t    fault_o
);

    // Combinational bounds tests, qualified by the access flag.
    always_comb begin
        fault_o       = FAULT_NONE;
        fault_o.under = vld_i && (ea_i < BASE);
        fault_o.over  = vld_i && armed_i && (ea_i > lim_i);
    end

endmodule

// File: rtl/stk_trap.sv
// Module: sticky trap request holder.
// Does: accumulates fault causes until cleared and reports the trap level.
// Assumes: a fault in the clearing cycle survives the clear.
module stk_trap
    import stk_guard_pkg::*;
#(
    parameter int unsigned        LW  = 4,
    parameter logic [LW-1:0]      LVL = 4'd12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_fault_t    fault_i,
    input  logic          clr_i,
    output logic          under_o,
    output logic          over_o,
    output logic          trap_o,
    output logic [LW-1:0] lvl_o
);

    stk_fault_t cause_q;

    // Sticky cause flags: clear first, then OR in the new fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= FAULT_NONE;
        end else begin
            cause_q.under <= (cause_q.under && !clr_i) || fault_i.under;
            cause_q.over  <= (cause_q.over  && !clr_i) || fault_i.over;
        end
    end

    assign under_o = cause_q.under;
    assign over_o  = cause_q.over;
    assign trap_o  = cause_q.under || cause_q.over;
    assign lvl_o   = trap_o ? LVL : '0;

endmodule

// File: rtl/stk_guard.sv
// Module: stack pointer bounds guard (top).
// Does: checks stack-pointer effective addresses against the reset base and a
// programmable limit, and raises a sticky soft-trap request.
// Assumes: one address per cycle; the limit write and the check share a clock.
module stk_guard
    import stk_guard_pkg::*;
#(
    parameter int unsigned   AW   = 16,
    parameter logic [AW-1:0] BASE = 16'h0800,
    parameter int unsigned   LW   = 4,
    parameter logic [LW-1:0] LVL  = 4'd12,
    localparam int unsigned  NL   = AW / LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ea_i,
    input  logic          ea_vld_i,
    input  logic          lim_wr_i,
    input  logic [NL-1:0] lim_be_i,
    input  logic [AW-1:0] lim_wdata_i,
    output logic [AW-1:0] lim_rdata_o,
    input  logic          trap_clr_i,
    output logic          trap_o,
    output logic          under_o,
    output logic          over_o,
    output logic [LW-1:0] trap_lvl_o
);

    logic [AW-1:0] lim_q;
    logic          lim_armed;
    stk_fault_t    fault;

    stk_lim_reg #(.AW(AW)) u_lim (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (lim_wr_i),
        .be_i    (lim_be_i),
        .wdata_i (lim_wdata_i),
        .lim_o   (lim_q),
        .armed_o (lim_armed)
    );

    stk_cmp #(.AW(AW), .BASE(BASE)) u_cmp (
        .vld_i   (ea_vld_i),
        .ea_i    (ea_i),
        .lim_i   (lim_q),
        .armed_i (lim_armed),
        .fault_o (fault)
    );

    stk_trap #(.LW(LW), .LVL(LVL)) u_trap (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_i (fault),
        .clr_i   (trap_clr_i),
        .under_o (under_o),
        .over_o  (over_o),
        .trap_o  (trap_o),
        .lvl_o   (trap_lvl_o)
    );

    assign lim_rdata_o = lim_q;

endmodule

// File: rtl/stk_guard_chk.sv
// Module: property checker for the stack bounds guard, bound to the top.
module stk_guard_chk #(
    parameter int unsigned   AW   = 16,
    parameter logic [AW-1:0] BASE = 16'h0800,
    parameter int unsigned   NL   = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] ea_i,
    input logic          ea_vld_i,
    input logic          lim_wr_i,
    input logic [NL-1:0] lim_be_i,
    input logic [AW-1:0] lim_q,
    input logic          lim_armed,
    input logic          trap_clr_i,
    input logic          trap_o,
    input logic          under_o,
    input logic          over_o
);

    // R2: a low address is latched as an underflow trap.
    a_r2_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_vld_i && (ea_i < BASE)) |=> (trap_o && under_o));

    // R6: an address past the armed limit is latched as an overflow trap.
    a_r6_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_vld_i && lim_armed && (ea_i > lim_q)) |=> (trap_o && over_o));

    // R3: no overflow cause can appear while the limit is disarmed.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!lim_armed && !over_o) |=> !over_o);

    // R5: a partial write never arms the comparison.
    a_r5_byte_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (!lim_armed && !(lim_wr_i && (&lim_be_i))) |=> !lim_armed);

    // R8: a pending trap holds without a clear.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && !trap_clr_i) |=> trap_o);

    // R7: no qualified access means no new trap.
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_o && !ea_vld_i) |=> !trap_o);

endmodule

bind stk_guard stk_guard_chk #(.AW(AW), .BASE(BASE), .NL(NL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ea_i       (ea_i),
    .ea_vld_i   (ea_vld_i),
    .lim_wr_i   (lim_wr_i),
    .lim_be_i   (lim_be_i),
    .lim_q      (lim_q),
    .lim_armed  (lim_armed),
    .trap_clr_i (trap_clr_i),
    .trap_o     (trap_o),
    .under_o    (under_o),
    .over_o     (over_o)
);

// File: tb/stk_guard_bench.sv
// Bench: sweeps addresses around both bounds with an arithmetic reference model.
module stk_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ea_i = '0;
    logic        ea_vld_i = 1'b0;
    logic        lim_wr_i = 1'b0;
    logic [1:0]  lim_be_i = '0;
    logic [15:0] lim_wdata_i = '0;
    logic [15:0] lim_rdata_o;
    logic        trap_clr_i = 1'b0;
    logic        trap_o, under_o, over_o;
    logic [3:0]  trap_lvl_o;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic        m_under = 1'b0, m_over = 1'b0, m_armed = 1'b0;
    logic [15:0] m_lim = '0;

    always #5 clk = ~clk;

    stk_guard u_stk_guard (
        .clk(clk), .rst_n(rst_n), .ea_i(ea_i), .ea_vld_i(ea_vld_i),
        .lim_wr_i(lim_wr_i), .lim_be_i(lim_be_i), .lim_wdata_i(lim_wdata_i),
        .lim_rdata_o(lim_rdata_o), .trap_clr_i(trap_clr_i), .trap_o(trap_o),
        .under_o(under_o), .over_o(over_o), .trap_lvl_o(trap_lvl_o)
    );

    task automatic compare(input string tag);
        logic [3:0] e_lvl;
        logic       e_trap;
        e_trap = m_under | m_over;
        e_lvl  = e_trap ? 4'd12 : 4'd0;
        checks++;
        if (trap_o !== e_trap || under_o !== m_under || over_o !== m_over ||
            trap_lvl_o !== e_lvl || (m_armed && lim_rdata_o !== m_lim)) begin
            errors++;
            $display("FAIL %s: trap/under/over/lvl/lim = %b/%b/%b/%0d/%h expected %b/%b/%b/%0d/%h",
                     tag, trap_o, under_o, over_o, trap_lvl_o, lim_rdata_o,
                     e_trap, m_under, m_over, e_lvl, m_lim);
        end
    endtask

    // One clock: drive at negedge, update model at the edge, compare after it.
    task automatic step(input logic v, input logic [15:0] ea, input logic wr,
                        input logic [1:0] be, input logic [15:0] d,
                        input logic clr, input string tag);
        logic fu, fo;
        @(negedge clk);
        ea_vld_i = v; ea_i = ea; lim_wr_i = wr; lim_be_i = be;
        lim_wdata_i = d; trap_clr_i = clr;
        @(posedge clk);
        fu = v && (ea < 16'h0800);
        fo = v && m_armed && (ea > m_lim);
        m_under = (m_under && !clr) || fu;
        m_over  = (m_over  && !clr) || fo;
        if (wr) begin
            if (be[0]) m_lim[7:0]  = d[7:0];
            if (be[1]) m_lim[15:8] = d[15:8];
            if (be == 2'b11) m_armed = 1'b1;
        end
        #1;
        compare(tag);
    endtask

    task automatic access(input logic [15:0] ea, input string tag);
        step(1'b1, ea, 1'b0, 2'b00, 16'h0, 1'b0, tag);
    endtask

    task automatic clear_trap();
        step(1'b0, 16'h0, 1'b0, 2'b00, 16'h0, 1'b1, "R8 clear");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R3: disarmed, every address at or above the base is accepted
        for (int a = 16'h0800; a <= 16'hFFFF; a += 16'h01F3) access(16'(a), "R3 disarmed sweep");
        access(16'hFFFF, "R3 top address disarmed");
        access(16'h0800, "R2 base equal no trap");

        // R7: low addresses without the qualifier are ignored
        step(1'b0, 16'h0000, 1'b0, 2'b00, 16'h0, 1'b0, "R7 unqualified low address");
        step(1'b0, 16'h07FF, 1'b0, 2'b00, 16'h0, 1'b0, "R7 unqualified below base");

        // R2: underflow sweep, each followed by a clear
        for (int a = 0; a < 16'h0800; a += 16'h0031) begin
            access(16'(a), "R2 underflow sweep");
            clear_trap();
        end
        access(16'h07FF, "R2 one below base");
        clear_trap();

        // R5: partial writes do not arm
        step(1'b0, 16'h0, 1'b1, 2'b01, 16'h0010, 1'b0, "R5 low byte write");
        step(1'b0, 16'h0, 1'b1, 2'b10, 16'h1000, 1'b0, "R5 high byte write");
        access(16'hFFFF, "R5 still disarmed after byte writes");

        // R4: full word write arms and reads back
        step(1'b0, 16'h0, 1'b1, 2'b11, 16'h1234, 1'b0, "R4 word write");

        // R6: overflow boundary and sweep
        access(16'h1233, "R6 below limit");
        access(16'h1234, "R6 equal limit");
        access(16'h1235, "R6 one above limit");
        clear_trap();
        for (int a = 16'h0800; a <= 16'hFFFF; a += 16'h02AB) begin
            access(16'(a), "R6 armed sweep");
            clear_trap();
        end

        // R5: byte write on an armed limit changes one lane only
        step(1'b0, 16'h0, 1'b1, 2'b10, 16'h20FF, 1'b0, "R5 high lane only");
        step(1'b0, 16'h0, 1'b1, 2'b01, 16'hAA35, 1'b0, "R5 low lane only");
        access(16'h2035, "R6 new limit equal");
        access(16'h2036, "R6 new limit above");

        // R8 and R10: causes accumulate and hold
        access(16'h0100, "R8 add underflow cause");
        step(1'b0, 16'h0, 1'b0, 2'b00, 16'h0, 1'b0, "R8 held idle");
        step(1'b0, 16'h0, 1'b0, 2'b00, 16'h0, 1'b0, "R10 level while held");
        clear_trap();

        // R9: new fault in the clearing cycle survives
        access(16'h0200, "R9 setup underflow");
        step(1'b1, 16'hF000, 1'b0, 2'b00, 16'h0, 1'b1, "R9 clear with overflow");
        step(1'b1, 16'h0010, 1'b0, 2'b00, 16'h0, 1'b1, "R9 clear with underflow");
        clear_trap();

        // R11: same-cycle write compares against the old limit
        step(1'b1, 16'h1000, 1'b1, 2'b11, 16'h0900, 1'b0, "R11 old limit used");
        access(16'h1000, "R11 new limit next cycle");
        clear_trap();

        // R1: reset clears the trap and disarms
        access(16'hFFFF, "R1 setup before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        m_under = 1'b0; m_over = 1'b0; m_armed = 1'b0;
        #1;
        compare("R1 reset clears trap");
        @(negedge clk);
        rst_n = 1'b1;
        access(16'hFFFF, "R1 disarmed after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule